// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Controller

This block sits beside a processor's exception logic. Once per clock it decides whether the pending interrupt can be taken. It compares the pending level with the interrupt level held in the status word. It also checks that at least one line mapped to that level is both raised and enabled. When the interrupt is taken, the block produces the next program counter and the new status word, records the interrupted state in its save registers, and pulses a taken indication.

Interrupts above level 1 each have their own vector and their own pair of save registers, holding the interrupted PC and the interrupted status. A level-1 interrupt is not vectored directly. It becomes a general exception, loads a cause code, and goes to one of three vectors. It uses the double-exception vector when the exception-mode bit is already set. Otherwise it uses the user vector when the user-mode bit is set, and the kernel vector when it is not. Vector addresses can follow a run-time vector-base input, or they can stay at the base fixed by a parameter. A parameter also chooses whether a dedicated double-exception PC register exists.

Status word layout: bits [3:0] hold the current interrupt level, bit 4 is the exception-mode bit and bit 5 is the user-mode bit.

Top module: `irq_dispatch`

## Requirements
- R1: An interrupt is taken only when the pending level is non-zero, no greater than NLEVEL, and strictly greater than status bits [3:0].
- R2: An interrupt is taken only when some line is set in that level's mask slice, in the set vector and in the enable vector together. Level L owns mask bits [(L-1)*NLINE +: NLINE].
- R3: When level L > 1 is taken, the save slots are written: epc_o slot L-1 gets the PC and eps_o slot L-2 gets the old status. The new status has bits [3:0] equal to L and bit 4 set, and all other bits are unchanged.
- R4: When level 1 is taken, cause_o becomes 4.
- R5: When level 1 is taken with status bit 4 set, the PC goes to depc_o if HAS_DEPC=1, otherwise to epc_o slot 0. The next PC is the double-exception vector.
- R6: When level 1 is taken with status bit 4 clear, the PC goes to epc_o slot 0. The next PC is the user vector if status bit 5 is set, otherwise the kernel vector.
- R7: When level 1 is taken, the new status equals the old status with bit 4 set.
- R8: The vector offset is L*VEC_STRIDE for level L. The kernel, user and double vectors use offsets (NLEVEL+1), (NLEVEL+2) and (NLEVEL+3) times VEC_STRIDE. With RELOC=1 the vector is vecbase_i plus the offset; with RELOC=0 it is RST_VECBASE plus the offset.
- R9: Results appear one clock after the inputs are sampled. When nothing is taken, take_o is 0, pc_next_o and ps_next_o repeat the sampled PC and status, and no save register changes.
- R10: While reset is asserted nothing is taken, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_lvl_i | input | LVLW | Pending interrupt level (0 = none) |
| lvl_mask_i | input | NLEVEL*NLINE | Line mask for each level, level L in slice L-1 |
| int_set_i | input | NLINE | Raised interrupt lines |
| int_en_i | input | NLINE | Enabled interrupt lines |
| ps_i | input | XLEN | Current status word |
| pc_i | input | XLEN | Current program counter |
| vecbase_i | input | XLEN | Run-time vector base |
| take_o | output | 1 | One-cycle pulse for each dispatch |
| pc_next_o | output | XLEN | Next program counter |
| ps_next_o | output | XLEN | Next status word |
| epc_o | output | NLEVEL*XLEN | Saved PC for each level, level L in slot L-1 |
| eps_o | output | (NLEVEL-1)*XLEN | Saved status for levels 2..NLEVEL, level L in slot L-2 |
| depc_o | output | XLEN | Double-exception saved PC (0 when absent) |
| cause_o | output | 8 | Exception cause |

## Verification
The bench sweeps these inputs together:
- every pending level, including 0 and values above NLEVEL;
- current levels on both sides of each pending level;
- both states of the exception-mode bit and of the user-mode bit;
- all set vectors against several enable vectors.

The level sweep separates a strict from an inclusive comparison and catches a missing upper bound. The set/enable sweep shows whether the mask, set and enable vectors are all really combined. The mode-bit combinations select among the kernel, user and double vectors and the two level-1 save targets. Two instances run side by side, one relocating and holding a double-exception PC register, the other fixed-base and without that register. Together they separate the vector-base variants and the save-target variants.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   localparam int PS_LVL_W    = 4;
   localparam int PS_EXCM_BIT = 4;
   localparam int PS_UM_BIT   = 5;
   localparam logic [7:0] CAUSE_LVL1_IRQ = 8'd4;

   typedef enum logic [1:0] {
      VK_LEVEL  = 2'd0,
      VK_KERNEL = 2'd1,
      VK_USER   = 2'd2,
      VK_DOUBLE = 2'd3
   } vec_kind_e;
endpackage

// File: rtl/irqd_accept.sv
module irqd_accept #(
   parameter int NLEVEL = 4,
   parameter int NLINE  = 8,
   parameter int LVLW   = 3
) (
   input  logic [LVLW-1:0]         pend_lvl,
   input  logic [3:0]              cur_lvl,
   input  logic [NLEVEL*NLINE-1:0] lvl_mask,
   input  logic [NLINE-1:0]        int_set,
   input  logic [NLINE-1:0]        int_en,
   output logic                    accept
);
   logic [NLEVEL:0] lvl_hit;
   logic            sel_hit;

   assign lvl_hit[0] = 1'b0;

   for (genvar l = 1; l <= NLEVEL; l++) begin : g_lvl
      assign lvl_hit[l] = |(lvl_mask[(l-1)*NLINE +: NLINE] & int_set & int_en);
   end

   always_comb begin
      sel_hit = 1'b0;
      for (int l = 1; l <= NLEVEL; l++) begin
         if (pend_lvl == LVLW'(l)) sel_hit = lvl_hit[l];
      end
   end

   assign accept = sel_hit && (4'(pend_lvl) > cur_lvl);
endmodule

// File: rtl/irqd_vector.sv
module irqd_vector
   import irqd_pkg::*;
#(
   parameter int              XLEN        = 32,
   parameter int              NLEVEL      = 4,
   parameter int              LVLW        = 3,
   parameter bit              RELOC       = 1'b1,
   parameter logic [XLEN-1:0] RST_VECBASE = '0,
   parameter logic [XLEN-1:0] VEC_STRIDE  = 'h40
) (
   input  vec_kind_e       kind,
   input  logic [LVLW-1:0] lvl,
   input  logic [XLEN-1:0] vecbase,
   output logic [XLEN-1:0] vec
);
   localparam int IW = $clog2(NLEVEL + 4);

   logic [IW-1:0]   slot;
   logic [XLEN-1:0] offset;
   logic [XLEN-1:0] static_vec;

   always_comb begin
      unique case (kind)
         VK_KERNEL: slot = IW'(NLEVEL + 1);
         VK_USER:   slot = IW'(NLEVEL + 2);
         VK_DOUBLE: slot = IW'(NLEVEL + 3);
         default:   slot = IW'(lvl);
      endcase
   end

   assign offset     = XLEN'(slot) * VEC_STRIDE;
   assign static_vec = RST_VECBASE + offset;

   if (RELOC) begin : g_reloc
      assign vec = static_vec - RST_VECBASE + vecbase;
   end else begin : g_fixed
      logic unused_base;
      assign unused_base = ^vecbase;
      assign vec = static_vec;
   end
endmodule

// File: rtl/irqd_savefile.sv
module irqd_savefile #(
   parameter int XLEN     = 32,
   parameter int NLEVEL   = 4,
   parameter int LVLW     = 3,
   parameter bit HAS_DEPC = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       we_epc,
   input  logic                       we_eps,
   input  logic                       we_depc,
   input  logic                       we_cause,
   input  logic [LVLW-1:0]            wr_lvl,
   input  logic [XLEN-1:0]            pc_d,
   input  logic [XLEN-1:0]            ps_d,
   input  logic [7:0]                 cause_d,
   output logic [NLEVEL*XLEN-1:0]     epc_o,
   output logic [(NLEVEL-1)*XLEN-1:0] eps_o,
   output logic [XLEN-1:0]            depc_o,
   output logic [7:0]                 cause_o
);
   for (genvar l = 1; l <= NLEVEL; l++) begin : g_epc
      logic [XLEN-1:0] epc_q;
      always_ff @(posedge clk) begin
         if (rst)                                 epc_q <= '0;
         else if (we_epc && wr_lvl == LVLW'(l))   epc_q <= pc_d;
      end
      assign epc_o[(l-1)*XLEN +: XLEN] = epc_q;
   end

   for (genvar l = 2; l <= NLEVEL; l++) begin : g_eps
      logic [XLEN-1:0] eps_q;
      always_ff @(posedge clk) begin
         if (rst)                                 eps_q <= '0;
         else if (we_eps && wr_lvl == LVLW'(l))   eps_q <= ps_d;
      end
      assign eps_o[(l-2)*XLEN +: XLEN] = eps_q;
   end

   if (HAS_DEPC) begin : g_depc
      logic [XLEN-1:0] depc_q;
      always_ff @(posedge clk) begin
         if (rst)          depc_q <= '0;
         else if (we_depc) depc_q <= pc_d;
      end
      assign depc_o = depc_q;
   end else begin : g_no_depc
      assign depc_o = '0;
   end

   logic [7:0] cause_q;
   always_ff @(posedge clk) begin
      if (rst)           cause_q <= '0;
      else if (we_cause) cause_q <= cause_d;
   end
   assign cause_o = cause_q;

   // R5
   one_pc_target_chk: assert property (@(posedge clk) disable iff (rst)
      !(we_depc && we_epc));

   // R9
   epc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !we_epc && !we_depc && !we_eps && !we_cause |=>
      $stable(epc_o) && $stable(eps_o) && $stable(depc_o) && $stable(cause_o));
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
   import irqd_pkg::*;
#(
   parameter int              XLEN        = 32,
   parameter int              NLEVEL      = 4,
   parameter int              NLINE       = 8,
   parameter bit              HAS_DEPC    = 1'b1,
   parameter bit              RELOC       = 1'b1,
   parameter logic [XLEN-1:0] RST_VECBASE = 'h4000_0000,
   parameter logic [XLEN-1:0] VEC_STRIDE  = 'h40,
   localparam int             LVLW        = $clog2(NLEVEL + 1)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [LVLW-1:0]            pend_lvl_i,
   input  logic [NLEVEL*NLINE-1:0]    lvl_mask_i,
   input  logic [NLINE-1:0]           int_set_i,
   input  logic [NLINE-1:0]           int_en_i,
   input  logic [XLEN-1:0]            ps_i,
   input  logic [XLEN-1:0]            pc_i,
   input  logic [XLEN-1:0]            vecbase_i,
   output logic                       take_o,
   output logic [XLEN-1:0]            pc_next_o,
   output logic [XLEN-1:0]            ps_next_o,
   output logic [NLEVEL*XLEN-1:0]     epc_o,
   output logic [(NLEVEL-1)*XLEN-1:0] eps_o,
   output logic [XLEN-1:0]            depc_o,
   output logic [7:0]                 cause_o
);
   if (NLEVEL < 2 || NLEVEL > 15) begin : g_bad_nlevel
      $error("irq_dispatch: NLEVEL must lie in 2..15");
   end
   if (XLEN < 8) begin : g_bad_xlen
      $error("irq_dispatch: XLEN must be at least 8");
   end
   if (NLINE < 1) begin : g_bad_nline
      $error("irq_dispatch: NLINE must be at least 1");
   end

   logic [3:0]      cur_lvl;
   logic [3:0]      pend4;
   logic            excm, um, is_l1, accept;
   vec_kind_e       kind;
   logic [XLEN-1:0] vec;
   logic [XLEN-1:0] ps_new;
   logic            we_epc, we_eps, we_depc, we_cause;

   assign cur_lvl = ps_i[PS_LVL_W-1:0];
   assign pend4   = 4'(pend_lvl_i);
   assign excm    = ps_i[PS_EXCM_BIT];
   assign um      = ps_i[PS_UM_BIT];
   assign is_l1   = (pend_lvl_i == LVLW'(1));

   irqd_accept #(.NLEVEL(NLEVEL), .NLINE(NLINE), .LVLW(LVLW)) u_accept (
      .pend_lvl (pend_lvl_i),
      .cur_lvl  (cur_lvl),
      .lvl_mask (lvl_mask_i),
      .int_set  (int_set_i),
      .int_en   (int_en_i),
      .accept   (accept)
   );

   always_comb begin
      if (!is_l1)    kind = VK_LEVEL;
      else if (excm) kind = VK_DOUBLE;
      else if (um)   kind = VK_USER;
      else           kind = VK_KERNEL;
   end

   irqd_vector #(
      .XLEN(XLEN), .NLEVEL(NLEVEL), .LVLW(LVLW), .RELOC(RELOC),
      .RST_VECBASE(RST_VECBASE), .VEC_STRIDE(VEC_STRIDE)
   ) u_vector (
      .kind    (kind),
      .lvl     (pend_lvl_i),
      .vecbase (vecbase_i),
      .vec     (vec)
   );

   always_comb begin
      ps_new = ps_i;
      ps_new[PS_EXCM_BIT] = 1'b1;
      if (!is_l1) ps_new[PS_LVL_W-1:0] = pend4;
   end

   assign we_depc  = accept && is_l1 && excm && HAS_DEPC;
   assign we_epc   = accept && !we_depc;
   assign we_eps   = accept && !is_l1;
   assign we_cause = accept && is_l1;

   irqd_savefile #(
      .XLEN(XLEN), .NLEVEL(NLEVEL), .LVLW(LVLW), .HAS_DEPC(HAS_DEPC)
   ) u_save (
      .clk      (clk),
      .rst      (rst),
      .we_epc   (we_epc),
      .we_eps   (we_eps),
      .we_depc  (we_depc),
      .we_cause (we_cause),
      .wr_lvl   (pend_lvl_i),
      .pc_d     (pc_i),
      .ps_d     (ps_i),
      .cause_d  (CAUSE_LVL1_IRQ),
      .epc_o    (epc_o),
      .eps_o    (eps_o),
      .depc_o   (depc_o),
      .cause_o  (cause_o)
   );

   logic            take_q;
   logic [XLEN-1:0] pc_q, ps_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         take_q <= 1'b0;
         pc_q   <= '0;
         ps_q   <= '0;
      end else begin
         take_q <= accept;
         pc_q   <= accept ? vec : pc_i;
         ps_q   <= accept ? ps_new : ps_i;
      end
   end

   assign take_o    = take_q;
   assign pc_next_o = pc_q;
   assign ps_next_o = ps_q;

   logic chk_arm_q;
   always_ff @(posedge clk) begin
      if (rst) chk_arm_q <= 1'b0;
      else     chk_arm_q <= 1'b1;
   end

   // R1
   level_window_chk: assert property (@(posedge clk) disable iff (rst)
      take_o |-> ($past(pend4) > $past(cur_lvl)) && ($past(pend4) <= 4'(NLEVEL)));

   // R2
   line_present_chk: assert property (@(posedge clk) disable iff (rst)
      take_o |-> |($past(int_set_i) & $past(int_en_i)));

   // R3
   high_level_ps_chk: assert property (@(posedge clk) disable iff (rst)
      take_o && $past(pend4) > 4'd1 |->
      ps_next_o[PS_LVL_W-1:0] == $past(pend4) && ps_next_o[PS_EXCM_BIT]);

   // R4
   l1_cause_chk: assert property (@(posedge clk) disable iff (rst)
      take_o && $past(pend4) == 4'd1 |-> cause_o == CAUSE_LVL1_IRQ);

   // R7
   excm_set_chk: assert property (@(posedge clk) disable iff (rst)
      take_o |-> ps_next_o[PS_EXCM_BIT]);

   // R9
   idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
      chk_arm_q && !take_o |-> pc_next_o == $past(pc_i) && ps_next_o == $past(ps_i));
endmodule

// File: tb/tb_irq_dispatch.sv
module tb_irq_dispatch;
   localparam int XLEN = 32, NLEVEL = 4, NLINE = 4, LVLW = 3;
   localparam logic [31:0] RSTB = 32'h4000_0000, STRIDE = 32'h40;

   logic clk = 1'b0, rst = 1'b1;
   always #5 clk = ~clk;

   logic [LVLW-1:0]          pend;
   logic [NLEVEL*NLINE-1:0]  masks;
   logic [NLINE-1:0]         iset, ien;
   logic [31:0]              ps, pc, vb;

   logic                     take [2];
   logic [31:0]              pcn [2], psn [2], depc [2];
   logic [NLEVEL*XLEN-1:0]   epc [2];
   logic [(NLEVEL-1)*XLEN-1:0] eps [2];
   logic [7:0]               cause [2];

   irq_dispatch #(.XLEN(XLEN), .NLEVEL(NLEVEL), .NLINE(NLINE), .HAS_DEPC(1'b1),
      .RELOC(1'b1), .RST_VECBASE(RSTB), .VEC_STRIDE(STRIDE)) dut (
      .clk(clk), .rst(rst), .pend_lvl_i(pend), .lvl_mask_i(masks),
      .int_set_i(iset), .int_en_i(ien), .ps_i(ps), .pc_i(pc), .vecbase_i(vb),
      .take_o(take[0]), .pc_next_o(pcn[0]), .ps_next_o(psn[0]), .epc_o(epc[0]),
      .eps_o(eps[0]), .depc_o(depc[0]), .cause_o(cause[0]));

   irq_dispatch #(.XLEN(XLEN), .NLEVEL(NLEVEL), .NLINE(NLINE), .HAS_DEPC(1'b0),
      .RELOC(1'b0), .RST_VECBASE(RSTB), .VEC_STRIDE(STRIDE)) dut_b (
      .clk(clk), .rst(rst), .pend_lvl_i(pend), .lvl_mask_i(masks),
      .int_set_i(iset), .int_en_i(ien), .ps_i(ps), .pc_i(pc), .vecbase_i(vb),
      .take_o(take[1]), .pc_next_o(pcn[1]), .ps_next_o(psn[1]), .epc_o(epc[1]),
      .eps_o(eps[1]), .depc_o(depc[1]), .cause_o(cause[1]));

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic        m_take [2];
   logic [31:0] m_pc [2], m_ps [2], m_depc [2];
   logic [31:0] m_epc [2][1:4];
   logic [31:0] m_eps [2][2:4];
   logic [7:0]  m_cause [2];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (pend=%0d ps=%h set=%h en=%h)",
                  tag, act, exp, pend, ps, iset, ien);
      end
   endtask

   function automatic logic [3:0] mask_of(input int l);
      case (l)
         1: return 4'b0011;
         2: return 4'b0100;
         3: return 4'b1000;
         4: return 4'b1001;
         default: return 4'b0000;
      endcase
   endfunction

   task automatic model(input int d, input bit hasd, input bit rl);
      int p = int'(pend);
      bit acc;
      logic [31:0] base;
      base = rl ? vb : RSTB;
      acc = p != 0 && p <= NLEVEL && p > int'(ps[3:0]) && |(mask_of(p) & iset & ien);
      m_take[d] = acc;
      if (!acc) begin
         m_pc[d] = pc;
         m_ps[d] = ps;
      end else if (p > 1) begin
         m_epc[d][p] = pc;
         m_eps[d][p] = ps;
         m_ps[d] = {ps[31:5], 1'b1, 4'(p)};
         m_pc[d] = base + 32'(p) * STRIDE;
      end else begin
         m_cause[d] = 8'd4;
         if (ps[4]) begin
            if (hasd) m_depc[d] = pc;
            else      m_epc[d][1] = pc;
            m_pc[d] = base + 32'(NLEVEL + 3) * STRIDE;
         end else begin
            m_epc[d][1] = pc;
            m_pc[d] = base + 32'(ps[5] ? NLEVEL + 2 : NLEVEL + 1) * STRIDE;
         end
         m_ps[d] = ps | 32'h10;
      end
   endtask

   task automatic compare(input int d);
      int p = int'(pend);
      string tpc, tps, tt;
      if (p == 0 || p > NLEVEL || p <= int'(ps[3:0])) tt = "R1";
      else tt = "R2";
      tpc = !m_take[d] ? "R9" : (p > 1 ? "R8" : (ps[4] ? "R5" : "R6"));
      tps = !m_take[d] ? "R9" : (p > 1 ? "R3" : "R7");
      chk(take[d] == m_take[d], tt, 32'(take[d]), 32'(m_take[d]));
      chk(pcn[d] == m_pc[d], tpc, pcn[d], m_pc[d]);
      chk(psn[d] == m_ps[d], tps, psn[d], m_ps[d]);
      chk(cause[d] == m_cause[d], "R4", 32'(cause[d]), 32'(m_cause[d]));
      chk(depc[d] == m_depc[d], "R5", depc[d], m_depc[d]);
      for (int l = 1; l <= NLEVEL; l++)
         chk(epc[d][(l-1)*32 +: 32] == m_epc[d][l], l == 1 ? "R6" : "R3",
             epc[d][(l-1)*32 +: 32], m_epc[d][l]);
      for (int l = 2; l <= NLEVEL; l++)
         chk(eps[d][(l-2)*32 +: 32] == m_eps[d][l], "R3",
             eps[d][(l-2)*32 +: 32], m_eps[d][l]);
   endtask

   initial begin
      for (int d = 0; d < 2; d++) begin
         m_take[d] = 0; m_pc[d] = 0; m_ps[d] = 0; m_depc[d] = 0; m_cause[d] = 0;
         for (int l = 1; l <= 4; l++) m_epc[d][l] = 0;
         for (int l = 2; l <= 4; l++) m_eps[d][l] = 0;
      end
      masks = {mask_of(4), mask_of(3), mask_of(2), mask_of(1)};
      pend = 3'd2; iset = 4'hF; ien = 4'hF; ps = 32'h0; pc = 32'h1234_5678;
      vb = 32'h2000_0000;
      repeat (3) @(negedge clk);
      // R10: acceptable interrupt held during reset, nothing taken
      for (int d = 0; d < 2; d++) begin
         chk(take[d] == 1'b0, "R10", 32'(take[d]), 0);
         chk(pcn[d] == 0 && psn[d] == 0, "R10", pcn[d] | psn[d], 0);
         chk(epc[d] == '0 && eps[d] == '0 && depc[d] == 0 && cause[d] == 0, "R10",
             epc[d][31:0] | eps[d][31:0] | depc[d] | 32'(cause[d]), 0);
      end
      rst = 1'b0;
      begin
         int n = 0;
         for (int p = 0; p < 8; p++)
            for (int c = 0; c < 6; c++)
               for (int md = 0; md < 4; md++)
                  for (int s = 0; s < 16; s++)
                     for (int e = 0; e < 4; e++) begin
                        pend = 3'(p);
                        ps   = 32'hABCD_0000 | (32'(md) << 4) | 32'(c);
                        iset = 4'(s);
                        case (e)
                           0: ien = 4'hF;
                           1: ien = 4'h5;
                           2: ien = 4'hA;
                           default: ien = 4'h0;
                        endcase
                        pc = 32'h1000_0000 + 32'(n) * 4;
                        vb = n[0] ? 32'h3000_0000 : 32'h2000_0000;
                        n++;
                        @(posedge clk);
                        model(0, 1'b1, 1'b1);
                        model(1, 1'b0, 1'b0);
                        @(negedge clk);
                        compare(0);
                        compare(1);
                     end
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule